// File: doc/BRIEF.md
# DMA Channel Bus-Ownership Scheduler

This block decides, for one DMA channel, when the channel asks for the system bus, when it starts a unit transfer, and when it gives the bus back. It sees a level-sensitive transfer request, the bus grant, a pulse marking the end of each unit transfer, an end-of-job flag, and the channel's mode settings. It drives a bus request, a one-cycle start strobe, and a flag for configurations that are not allowed. Address generation, data movement and arbitration between channels are handled elsewhere.

Three kinds of operation are supported. In plain cycle stealing the channel returns the bus after every unit. In spaced cycle stealing it also keeps a quiet gap of 16 or 64 clocks before it asks again. In burst operation it keeps the bus from the first grant until the job ends, or until the request line drops. An external hold input can delay a request that is ready to go out, for example while a cache refill is running. A channel-index parameter marks whether this channel belongs to the group that is allowed to burst.

Top module: `dma_bus_sched`

## Requirements
- R1: While reset is asserted, and on the first cycles after its synchronous release, bus_req, xfer_start and cfg_err are all 0 when the inputs are idle.
- R2: In an idle enabled channel, a high xfer_req raises bus_req one cycle later. bus_req then stays high until bus_gnt is seen. xfer_start is a one-cycle pulse and is only asserted in a cycle where bus_gnt is 1.
- R3: In cycle-steal modes (cyc_sel 00 or 01, or any setting other than lock_cfg=1 with ttype_cfg=1), bus_req is 0 in the cycle after every unit_done pulse.
- R4: With cyc_sel=10 the gap is N=16, and with cyc_sel=11 it is N=64. If unit_done is seen in cycle t and a request is pending, bus_req stays 0 through cycle t+N and rises in cycle t+N+1.
- R5: A request seen during the gap is latched and served when the gap ends, even if xfer_req has dropped by then. If no request was seen, the channel stays idle with bus_req 0.
- R6: Burst mode is lock_cfg=1 and ttype_cfg=1. In burst mode, if xfer_req is high at unit_done, bus_req stays high and the next xfer_start comes in the following cycle, provided bus_gnt is held.
- R7: In burst mode, if xfer_req is low at unit_done, bus_req is 0 in the next cycle.
- R8: If xfer_end is high at unit_done, bus_req drops in the next cycle. No new bus_req is raised while xfer_end stays high.
- R9: A burst setting with src_onchip=1 sets cfg_err, and the channel raises no bus_req.
- R10: With CHAN_IDX not below BURST_CHANS, any burst setting sets cfg_err and raises no bus_req, whatever src_onchip is.
- R11: A high hold_req keeps a ready request from raising bus_req. bus_req rises in the cycle after hold_req drops. hold_req has no effect on a handshake that has already started.
- R12: Dropping chan_en, or changing the decoded mode, during a gap cancels the gap. A request after re-enabling raises bus_req two cycles after chan_en dropped, without waiting for the gap to finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_en | input | 1 | Channel enable |
| xfer_req | input | 1 | Level-sensitive transfer request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| unit_done | input | 1 | One-cycle pulse at the end of a unit transfer |
| xfer_end | input | 1 | End-of-job condition (remaining count exhausted) |
| hold_req | input | 1 | Postpones issuing the next request |
| cyc_sel | input | 2 | Cycle-steal spacing: 10 is a 16-clock gap, 11 is a 64-clock gap, other codes mean no gap |
| lock_cfg | input | 1 | Bus-lock setting; burst when set together with ttype_cfg |
| ttype_cfg | input | 1 | Transfer-type setting; burst when set together with lock_cfg |
| src_onchip | input | 1 | Request source is an on-chip peripheral |
| bus_req | output | 1 | Bus request / bus held |
| xfer_start | output | 1 | One-cycle unit-start strobe |
| cfg_err | output | 1 | Illegal burst configuration |

## Verification
The assertions take for granted that bus_gnt is only high while bus_req is high and stays high for as long as the channel holds the bus. They also take for granted that unit_done arrives only after a unit has started, and as a single-cycle pulse. The stimulus keeps to these rules. It raises the grant only in cycles where the bench has already seen bus_req at the mid-cycle sample. It keeps the grant up until after the unit_done cycle. It pulses unit_done exactly once per started unit. Configuration inputs change only while the channel is idle, or, for the cancel case, during a gap.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  typedef enum logic [1:0] {
    MODE_STEAL = 2'd0,
    MODE_GAP_S = 2'd1,
    MODE_GAP_L = 2'd2,
    MODE_BURST = 2'd3
  } sched_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_BUSY  = 3'd2,
    ST_GAP   = 3'd3,
    ST_BNEXT = 3'd4
  } sched_state_e;

  localparam logic [1:0] CYC_GAP_SHORT = 2'b10;
  localparam logic [1:0] CYC_GAP_LONG  = 2'b11;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_sched_pkg::*;
#(
  parameter int unsigned CHAN_IDX    = 0,
  parameter int unsigned BURST_CHANS = 6
) (
  input  logic [1:0]  cyc_sel,
  input  logic        lock_cfg,
  input  logic        ttype_cfg,
  input  logic        src_onchip,
  output sched_mode_e mode,
  output logic        cfg_err
);

  logic burst_ok;
  logic burst_sel;

  generate
    if (CHAN_IDX < BURST_CHANS) begin : g_burst_group
      assign burst_ok = 1'b1;
    end else begin : g_steal_only
      assign burst_ok = 1'b0;
    end
  endgenerate

  assign burst_sel = lock_cfg & ttype_cfg;

  always_comb begin
    cfg_err = 1'b0;
    mode    = MODE_STEAL;
    if (burst_sel) begin
      if (!burst_ok || src_onchip) begin
        cfg_err = 1'b1;
        mode    = MODE_STEAL;
      end else begin
        mode    = MODE_BURST;
      end
    end else begin
      unique case (cyc_sel)
        CYC_GAP_SHORT: mode = MODE_GAP_S;
        CYC_GAP_LONG:  mode = MODE_GAP_L;
        default:       mode = MODE_STEAL;
      endcase
    end
  end

endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int unsigned GAP_SHORT = 16,
  parameter int unsigned GAP_LONG  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_long,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = $clog2(GAP_LONG + 1);
  localparam logic [CW-1:0] LOAD_SHORT = CW'(GAP_SHORT - 1);
  localparam logic [CW-1:0] LOAD_LONG  = CW'(GAP_LONG - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | load | (run & (cnt_q != '0));
    if (clear) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = use_long ? LOAD_LONG : LOAD_SHORT;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  AST_GAP_LOADED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> !expired); // R4

endmodule

// File: rtl/dma_sched_fsm.sv
module dma_sched_fsm
  import dma_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_en,
  input  logic        xfer_req,
  input  logic        bus_gnt,
  input  logic        unit_done,
  input  logic        xfer_end,
  input  logic        hold_req,
  input  sched_mode_e mode,
  input  logic        cfg_err,
  input  logic        gap_expired,
  output logic        bus_req,
  output logic        xfer_start,
  output logic        gap_load,
  output logic        gap_long,
  output logic        gap_clear,
  output logic        gap_run
);

  sched_state_e state_q;
  sched_state_e state_d;
  sched_mode_e  mode_q;
  logic         pend_q;
  logic         pend_d;
  logic         mode_chg;
  logic         abort;
  logic         pending;
  logic         may_issue;
  logic         is_burst;
  logic         is_gap;

  assign mode_chg  = (mode != mode_q);
  assign abort     = !chan_en || mode_chg;
  assign pending   = xfer_req || pend_q;
  assign may_issue = chan_en && !cfg_err && !xfer_end && !hold_req;
  assign is_burst  = (mode == MODE_BURST);
  assign is_gap    = (mode == MODE_GAP_S) || (mode == MODE_GAP_L);

  always_comb begin
    state_d  = state_q;
    gap_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (may_issue && pending) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (bus_gnt) state_d = ST_BUSY;
      end
      ST_BUSY: begin
        if (unit_done) begin
          if (xfer_end || abort) begin
            state_d = ST_IDLE;
          end else if (is_burst) begin
            state_d = xfer_req ? ST_BNEXT : ST_IDLE;
          end else if (is_gap) begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (gap_expired) begin
          state_d = (may_issue && pending) ? ST_REQ : ST_IDLE;
        end
      end
      ST_BNEXT: begin
        if (bus_gnt && !hold_req) state_d = ST_BUSY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (abort || (state_d == ST_REQ)) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q | (xfer_req && (state_q == ST_GAP));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_STEAL;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode;
      pend_q  <= pend_d;
    end
  end

  assign bus_req    = (state_q == ST_REQ) || (state_q == ST_BUSY) || (state_q == ST_BNEXT);
  assign xfer_start = bus_gnt && ((state_q == ST_REQ) || ((state_q == ST_BNEXT) && !hold_req));
  assign gap_long   = (mode == MODE_GAP_L);
  assign gap_clear  = abort;
  assign gap_run    = (state_q == ST_GAP);

  AST_START_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> bus_gnt); // R2

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R2

  AST_REQ_NO_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_REQ) && !bus_gnt) |=> bus_req); // R2

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_BUSY) && unit_done && !is_burst) |=> !bus_req); // R3

  AST_BURST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_BUSY) && unit_done && is_burst && !xfer_req) |=> !bus_req); // R7

  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !bus_req) |=> !bus_req); // R8

  AST_CFG_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !bus_req) |=> !bus_req); // R9

  AST_HOLD_POSTPONES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && !bus_req) |=> !bus_req); // R11

  AST_DISABLE_CANCELS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_run && !chan_en) |=> (!bus_req && !gap_run)); // R12

endmodule

// File: rtl/dma_bus_sched.sv
module dma_bus_sched
  import dma_sched_pkg::*;
#(
  parameter int unsigned CHAN_IDX    = 0,
  parameter int unsigned BURST_CHANS = 6,
  parameter int unsigned GAP_SHORT   = 16,
  parameter int unsigned GAP_LONG    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       xfer_req,
  input  logic       bus_gnt,
  input  logic       unit_done,
  input  logic       xfer_end,
  input  logic       hold_req,
  input  logic [1:0] cyc_sel,
  input  logic       lock_cfg,
  input  logic       ttype_cfg,
  input  logic       src_onchip,
  output logic       bus_req,
  output logic       xfer_start,
  output logic       cfg_err
);

  logic        rst_n_int;
  sched_mode_e mode;
  logic        gap_load;
  logic        gap_long;
  logic        gap_clear;
  logic        gap_run;
  logic        gap_expired;

  dma_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dma_mode_decode #(
    .CHAN_IDX    (CHAN_IDX),
    .BURST_CHANS (BURST_CHANS)
  ) u_decode (
    .cyc_sel    (cyc_sel),
    .lock_cfg   (lock_cfg),
    .ttype_cfg  (ttype_cfg),
    .src_onchip (src_onchip),
    .mode       (mode),
    .cfg_err    (cfg_err)
  );

  dma_gap_timer #(
    .GAP_SHORT (GAP_SHORT),
    .GAP_LONG  (GAP_LONG)
  ) u_gap (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (gap_load),
    .use_long (gap_long),
    .clear    (gap_clear),
    .run      (gap_run),
    .expired  (gap_expired)
  );

  dma_sched_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .chan_en     (chan_en),
    .xfer_req    (xfer_req),
    .bus_gnt     (bus_gnt),
    .unit_done   (unit_done),
    .xfer_end    (xfer_end),
    .hold_req    (hold_req),
    .mode        (mode),
    .cfg_err     (cfg_err),
    .gap_expired (gap_expired),
    .bus_req     (bus_req),
    .xfer_start  (xfer_start),
    .gap_load    (gap_load),
    .gap_long    (gap_long),
    .gap_clear   (gap_clear),
    .gap_run     (gap_run)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_int |-> (!bus_req && !xfer_start)); // R1

endmodule

// File: tb/dma_bus_sched_tb.sv
`timescale 1ns/1ps
module dma_bus_sched_tb;

  logic       clk;
  logic       rst_n;
  logic       chan_en, xfer_req, bus_gnt, unit_done, xfer_end, hold_req;
  logic [1:0] cyc_sel;
  logic       lock_cfg, ttype_cfg, src_onchip;
  logic       bus_req, xfer_start, cfg_err;
  logic       hi_bus_req, hi_xfer_start, hi_cfg_err;

  int tests;
  int fails;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  dma_bus_sched u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .xfer_req(xfer_req),
    .bus_gnt(bus_gnt), .unit_done(unit_done), .xfer_end(xfer_end),
    .hold_req(hold_req), .cyc_sel(cyc_sel), .lock_cfg(lock_cfg),
    .ttype_cfg(ttype_cfg), .src_onchip(src_onchip),
    .bus_req(bus_req), .xfer_start(xfer_start), .cfg_err(cfg_err)
  );

  dma_bus_sched #(.CHAN_IDX(8), .BURST_CHANS(6)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .xfer_req(xfer_req),
    .bus_gnt(bus_gnt), .unit_done(unit_done), .xfer_end(xfer_end),
    .hold_req(hold_req), .cyc_sel(cyc_sel), .lock_cfg(lock_cfg),
    .ttype_cfg(ttype_cfg), .src_onchip(src_onchip),
    .bus_req(hi_bus_req), .xfer_start(hi_xfer_start), .cfg_err(hi_cfg_err)
  );

  // {en,req,gnt,done,end,cyc[1:0],lock,ttype,onchip,hold, exp_req,exp_start,exp_err}
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    14'b10000_00_0000_000,  // idle
    14'b11000_00_0000_000,  // R2 request seen
    14'b11000_00_0000_100,  // R2 bus_req up
    14'b11000_00_0000_100,  // R2 held without grant
    14'b11100_00_0000_110,  // R2 start with grant
    14'b11100_00_0000_100,
    14'b11110_00_0000_100,  // unit done
    14'b11000_00_0000_000,  // R3 released
    14'b11000_00_0000_100,
    14'b11100_00_0000_110,
    14'b11111_00_0000_100,  // done with end
    14'b11001_00_0000_000,  // R8 no request
    14'b11001_00_0000_000,  // R8
    14'b11000_00_1110_001,  // R9 burst from on-chip source
    14'b11000_00_1110_001,  // R9
    14'b10000_00_0000_000
  };

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Entered at posedge+1; returns at posedge+1 of the cycle after unit_done.
  task automatic run_unit(input logic req_at_done, input logic end_at_done,
                          input logic keep_gnt);
    int guard;
    xfer_req = 1'b1;
    guard = 0;
    @(negedge clk);
    while (!bus_req && guard < 200) begin
      tick();
      @(negedge clk);
      guard++;
    end
    if (guard >= 200) check("R2 request never raised", 1'b0, 1'b1);
    tick();
    bus_gnt = 1'b1;
    @(negedge clk);
    check("R2 start strobe with grant", xfer_start, 1'b1);
    tick();
    unit_done = 1'b1;
    xfer_req  = req_at_done;
    xfer_end  = end_at_done;
    tick();
    unit_done = 1'b0;
    if (!keep_gnt) bus_gnt = 1'b0;
  endtask

  task automatic gap_window(input int n, input string tag, input int pulse_at);
    logic quiet;
    quiet = 1'b1;
    for (int k = 1; k <= n; k++) begin
      if (pulse_at > 0) xfer_req = (k == pulse_at);
      @(negedge clk);
      if (bus_req) quiet = 1'b0;
      tick();
    end
    check(tag, quiet, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0;
    {chan_en, xfer_req, bus_gnt, unit_done, xfer_end, hold_req} = '0;
    cyc_sel = 2'b00; lock_cfg = 1'b0; ttype_cfg = 1'b0; src_onchip = 1'b0;

    repeat (3) tick();
    @(negedge clk);
    check("R1 reset bus_req", bus_req, 1'b0);
    check("R1 reset xfer_start", xfer_start, 1'b0);
    check("R1 reset cfg_err", cfg_err, 1'b0);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    check("R1 after release bus_req", bus_req, 1'b0);
    tick();

    // Table walk: R2 R3 R8 R9
    for (int i = 0; i < NV; i++) begin
      {chan_en, xfer_req, bus_gnt, unit_done, xfer_end, cyc_sel,
       lock_cfg, ttype_cfg, src_onchip, hold_req} = VEC[i][13:3];
      @(negedge clk);
      check($sformatf("R2 R3 R8 R9 vector %0d bus_req", i), bus_req, VEC[i][2]);
      check($sformatf("R2 vector %0d xfer_start", i), xfer_start, VEC[i][1]);
      check($sformatf("R9 vector %0d cfg_err", i), cfg_err, VEC[i][0]);
      tick();
    end

    // R4 short gap with request held
    cyc_sel = 2'b10; xfer_req = 1'b0;
    tick();
    run_unit(1'b1, 1'b0, 1'b0);
    gap_window(16, "R4 gap16 quiet", 0);
    @(negedge clk);
    check("R4 gap16 reissue", bus_req, 1'b1);
    tick();

    // R5 request pulse during gap is latched
    run_unit(1'b0, 1'b0, 1'b0);
    gap_window(16, "R5 latch gap quiet", 5);
    @(negedge clk);
    check("R5 latched request served", bus_req, 1'b1);
    tick();
    run_unit(1'b0, 1'b1, 1'b0);
    xfer_end = 1'b0;
    tick();

    // R5 no request during gap -> idle
    run_unit(1'b0, 1'b0, 1'b0);
    gap_window(20, "R5 idle after gap", 0);

    // R4 long gap
    cyc_sel = 2'b11;
    tick();
    run_unit(1'b1, 1'b0, 1'b0);
    gap_window(64, "R4 gap64 quiet", 0);
    @(negedge clk);
    check("R4 gap64 reissue", bus_req, 1'b1);
    tick();
    run_unit(1'b0, 1'b1, 1'b0);
    xfer_end = 1'b0;
    tick();

    // R12 disable during gap cancels it
    run_unit(1'b1, 1'b0, 1'b0);
    tick();
    chan_en = 1'b0;
    tick();
    chan_en = 1'b1;
    @(negedge clk);
    check("R12 idle after disable", bus_req, 1'b0);
    tick();
    @(negedge clk);
    check("R12 request without waiting gap", bus_req, 1'b1);
    tick();
    run_unit(1'b0, 1'b1, 1'b0);
    xfer_end = 1'b0;
    tick();

    // R11 hold postpones request, not the handshake
    cyc_sel = 2'b00;
    hold_req = 1'b1; xfer_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 held request not issued", bus_req, 1'b0);
      tick();
    end
    hold_req = 1'b0;
    @(negedge clk);
    check("R11 hold just dropped", bus_req, 1'b0);
    tick();
    hold_req = 1'b1;
    @(negedge clk);
    check("R11 request after hold drop", bus_req, 1'b1);
    tick();
    @(negedge clk);
    check("R11 hold does not withdraw", bus_req, 1'b1);
    tick();
    bus_gnt = 1'b1;
    @(negedge clk);
    check("R11 start despite hold", xfer_start, 1'b1);
    tick();
    unit_done = 1'b1; xfer_req = 1'b0; hold_req = 1'b0;
    tick();
    unit_done = 1'b0; bus_gnt = 1'b0;
    @(negedge clk);
    check("R3 released after unit", bus_req, 1'b0);
    tick();

    // R10 channel index outside burst group; R6 R7 burst
    lock_cfg = 1'b1; ttype_cfg = 1'b1; src_onchip = 1'b0;
    @(negedge clk);
    check("R10 high channel rejects burst", hi_cfg_err, 1'b1);
    check("R10 low channel accepts burst", cfg_err, 1'b0);
    tick();
    run_unit(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R6 burst keeps bus", bus_req, 1'b1);
    check("R6 burst next start", xfer_start, 1'b1);
    check("R10 high channel no request", hi_bus_req, 1'b0);
    tick();
    unit_done = 1'b1; xfer_req = 1'b0;
    @(negedge clk);
    check("R6 bus held during unit", bus_req, 1'b1);
    tick();
    unit_done = 1'b0; bus_gnt = 1'b0;
    @(negedge clk);
    check("R7 burst released on request drop", bus_req, 1'b0);
    tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule